// File: doc/BRIEF.md
# Raster Display Controller Control and Status Unit

This unit holds the control register of a raster display controller and the latched event flags that its pixel datapath reports. Software programs a run bit, a panel-type bit, a two-bit load mode and five interrupt enables through a small word-addressed register bus. It reads back the event flags and acknowledges them through a second register. The unit drives a single interrupt line.

Turning the controller off is never abrupt. After software clears the run bit, the frame already on its way to the panel completes, and only then does the unit stop and raise its frame-done flag. Each event flag has its own rule for being cleared. Some are acknowledged by writing zero to them. Some go away only when software stops the controller. The done flag goes away only when the controller is started again. For the palette flag, the rule depends on the load mode.

The datapath is outside this unit and is seen only as one-cycle strobes: end of frame, vsync, sync lost, FIFO underflow, AC-bias count, line match and palette loaded.

Top module: `lcd_ctl_status`

## Requirements
- R1: After reset, the control word reads 0, the status word reads 0, `active_o` is low and `irq_o` is low.
- R2: The control register sits at word address 0. Its fields are: bit 0 run, bits 6:2 interrupt enables, bit 7 active-matrix panel, bits 21:20 load mode (01 palette only, 10 frame only, 00 palette then frame). The five enables are, from bit 2 upward: vsync, done, palette loaded, line match without interrupt, line match. Every other bit reads 0. `tft_o` shows bit 7 and `load_mode_o` shows bits 21:20.
- R3: A control write with bit 0 set makes `active_o` high from the next cycle on. A datapath strobe sets its flag only while `active_o` is high.
- R4: A control write with bit 0 clear, made while active, leaves `active_o` high until the next `frame_end_i` strobe. At that edge `active_o` falls and the done flag (status bit 0) is set. A control write with bit 0 set, made before that strobe, cancels the pending stop.
- R5: The done flag is not cleared by any status write. Only a control write with bit 0 set clears it.
- R6: Sync lost (status bit 2) and FIFO underflow (status bit 5) are cleared by a control write with bit 0 clear. Status writes leave them unchanged.
- R7: The status register sits at word address 1. A write there clears vsync (bit 1), AC-bias (bit 3) and line match (bit 4) wherever the written bit is 0. Where the written bit is 1, the flag keeps its value.
- R8: The palette-loaded flag (status bit 6) is cleared by a status write with bit 6 at 0 only when the load mode is 01. In any other load mode a status write leaves it unchanged, and a control write with bit 0 clear clears it.
- R9: `irq_o` is high when done is set with the done enable, vsync with the vsync enable, palette loaded with the palette enable, or line match with the line-match enable. The line-match-without-interrupt enable and the AC-bias flag never raise `irq_o`.
- R10: While sync lost or FIFO underflow is set, `irq_o` is high regardless of the enables.
- R11: If a flag's event and its clear fall in the same cycle, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Bus access strobe |
| bus_write_i | input | 1 | Access is a write |
| bus_addr_i | input | ADDR_W | Word address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data of the addressed word (combinational) |
| frame_end_i | input | 1 | Datapath strobe: last pixel of a frame sent |
| vsync_i | input | 1 | Datapath strobe: vertical sync |
| sync_lost_i | input | 1 | Datapath strobe: synchronisation lost |
| acb_i | input | 1 | Datapath strobe: AC-bias count reached |
| line_i | input | 1 | Datapath strobe: programmed line reached |
| fifo_underflow_i | input | 1 | Datapath strobe: pixel FIFO underflow |
| palette_done_i | input | 1 | Datapath strobe: palette load finished |
| active_o | output | 1 | Controller running |
| tft_o | output | 1 | Active-matrix panel selected |
| load_mode_o | output | 2 | Current load mode |
| irq_o | output | 1 | Interrupt request |

## Verification
All state changes land on the clock edge that samples the bus write or the strobe. Flags, `active_o`, `tft_o` and `load_mode_o` therefore change one edge after the stimulus. `irq_o` and the read data follow the flags combinationally, with no further delay. The bench drives stimulus on the falling edge and keeps it up for exactly one rising edge. It reads results on the falling edge that follows, so every check sits one edge after its stimulus. For the deferred stop, the bench checks `active_o` on several cycles between the control write and `frame_end_i` to confirm that nothing changes before that strobe.

// File: rtl/lcd_ctl_pkg.sv
package lcd_ctl_pkg;
  localparam int NUM_FLAGS = 7;

  // status bit positions
  localparam int FLG_DONE  = 0;
  localparam int FLG_VSYNC = 1;
  localparam int FLG_SYNC  = 2;
  localparam int FLG_ACB   = 3;
  localparam int FLG_LINE  = 4;
  localparam int FLG_FUF   = 5;
  localparam int FLG_PAL   = 6;

  // control bit positions
  localparam int CB_RUN   = 0;
  localparam int CB_IE_LO = 2;
  localparam int CB_IE_HI = 6;
  localparam int CB_TFT   = 7;
  localparam int CB_LM_LO = 20;
  localparam int CB_LM_HI = 21;

  typedef enum logic [1:0] {
    LM_PAL_FRAME = 2'b00,
    LM_PAL_ONLY  = 2'b01,
    LM_FRAME     = 2'b10,
    LM_RSVD      = 2'b11
  } load_mode_e;

  // packed msb first: bit 4 = control bit 6
  typedef struct packed {
    logic ie_line;
    logic ie_line_nirq;
    logic ie_pal;
    logic ie_done;
    logic ie_vsync;
  } irq_en_t;

  typedef struct packed {
    load_mode_e mode;
    logic       tft;
    irq_en_t    ie;
    logic       run;
  } ctrl_t;
endpackage

// File: rtl/lcd_ctl_regs.sv
module lcd_ctl_regs
  import lcd_ctl_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 2,
  parameter int CTRL_ADDR = 0,
  parameter int STAT_ADDR = 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic                 write_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic [NUM_FLAGS-1:0] status_i,
  output ctrl_t                ctrl_o,
  output logic                 run_set_o,
  output logic                 run_clr_o,
  output logic [NUM_FLAGS-1:0] wr_clr_o,
  output logic [DATA_W-1:0]    rdata_o
);
  localparam logic [ADDR_W-1:0] CtrlA = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] StatA = ADDR_W'(STAT_ADDR);

  logic  ctrl_wr, stat_wr;
  ctrl_t ctrl_q, ctrl_d;
  logic  unused_wdata;

  assign ctrl_wr = valid_i & write_i & (addr_i == CtrlA);
  assign stat_wr = valid_i & write_i & (addr_i == StatA);

  assign ctrl_d.run  = wdata_i[CB_RUN];
  assign ctrl_d.ie   = irq_en_t'(wdata_i[CB_IE_HI:CB_IE_LO]);
  assign ctrl_d.tft  = wdata_i[CB_TFT];
  assign ctrl_d.mode = load_mode_e'(wdata_i[CB_LM_HI:CB_LM_LO]);

  assign unused_wdata = ^{wdata_i[CB_IE_LO-1:CB_RUN+1], wdata_i[CB_LM_LO-1:CB_TFT+1],
                          wdata_i[DATA_W-1:CB_LM_HI+1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= ctrl_d;
  end

  assign ctrl_o    = ctrl_q;
  assign run_set_o = ctrl_wr & wdata_i[CB_RUN];
  assign run_clr_o = ctrl_wr & ~wdata_i[CB_RUN];
  assign wr_clr_o  = stat_wr ? ~wdata_i[NUM_FLAGS-1:0] : '0;

  always_comb begin
    rdata_o = '0;
    if (addr_i == CtrlA) begin
      rdata_o[CB_RUN]            = ctrl_q.run;
      rdata_o[CB_IE_HI:CB_IE_LO] = ctrl_q.ie;
      rdata_o[CB_TFT]            = ctrl_q.tft;
      rdata_o[CB_LM_HI:CB_LM_LO] = ctrl_q.mode;
    end else if (addr_i == StatA) begin
      rdata_o[NUM_FLAGS-1:0] = status_i;
    end
  end
endmodule

// File: rtl/lcd_ctl_seq.sv
module lcd_ctl_seq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_set_i,
  input  logic run_clr_i,
  input  logic frame_end_i,
  output logic active_o,
  output logic done_o
);
  logic active_q, stop_pend_q;

  // stop only at a frame boundary; a new run request cancels a pending stop
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q    <= 1'b0;
      stop_pend_q <= 1'b0;
    end else if (run_set_i) begin
      active_q    <= 1'b1;
      stop_pend_q <= 1'b0;
    end else if (stop_pend_q && frame_end_i) begin
      active_q    <= 1'b0;
      stop_pend_q <= 1'b0;
    end else if (run_clr_i && active_q) begin
      stop_pend_q <= 1'b1;
    end
  end

  assign active_o = active_q;
  assign done_o   = stop_pend_q & frame_end_i & ~run_set_i;
endmodule

// File: rtl/lcd_ctl_flags.sv
module lcd_ctl_flags
  import lcd_ctl_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_FLAGS-1:0] set_i,
  input  logic [NUM_FLAGS-1:0] wr_clr_i,
  input  logic                 run_set_i,
  input  logic                 run_clr_i,
  input  load_mode_e           mode_i,
  output logic [NUM_FLAGS-1:0] flags_o
);
  logic [NUM_FLAGS-1:0] clr;
  logic                 unused_clr;

  always_comb begin
    clr            = '0;
    clr[FLG_DONE]  = run_set_i;
    clr[FLG_VSYNC] = wr_clr_i[FLG_VSYNC];
    clr[FLG_SYNC]  = run_clr_i;
    clr[FLG_ACB]   = wr_clr_i[FLG_ACB];
    clr[FLG_LINE]  = wr_clr_i[FLG_LINE];
    clr[FLG_FUF]   = run_clr_i;
    clr[FLG_PAL]   = (mode_i == LM_PAL_ONLY) ? wr_clr_i[FLG_PAL] : run_clr_i;
  end

  assign unused_clr = ^{wr_clr_i[FLG_DONE], wr_clr_i[FLG_SYNC], wr_clr_i[FLG_FUF]};

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flags_o[i] <= 1'b0;
      else if (set_i[i])  flags_o[i] <= 1'b1;  // event beats clear
      else if (clr[i])    flags_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/lcd_ctl_irq.sv
module lcd_ctl_irq
  import lcd_ctl_pkg::*;
(
  input  logic [NUM_FLAGS-1:0] flags_i,
  input  irq_en_t              ie_i,
  output logic                 irq_o
);
  logic masked, fatal;
  logic unused_bits;

  assign masked = (flags_i[FLG_DONE]  & ie_i.ie_done)
                | (flags_i[FLG_VSYNC] & ie_i.ie_vsync)
                | (flags_i[FLG_PAL]   & ie_i.ie_pal)
                | (flags_i[FLG_LINE]  & ie_i.ie_line);
  assign fatal  = flags_i[FLG_SYNC] | flags_i[FLG_FUF];
  assign irq_o  = masked | fatal;

  assign unused_bits = flags_i[FLG_ACB] ^ ie_i.ie_line_nirq;
endmodule

// File: rtl/lcd_ctl_status.sv
module lcd_ctl_status
  import lcd_ctl_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 2,
  parameter int CTRL_ADDR = 0,
  parameter int STAT_ADDR = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              frame_end_i,
  input  logic              vsync_i,
  input  logic              sync_lost_i,
  input  logic              acb_i,
  input  logic              line_i,
  input  logic              fifo_underflow_i,
  input  logic              palette_done_i,
  output logic              active_o,
  output logic              tft_o,
  output logic [1:0]        load_mode_o,
  output logic              irq_o
);
  ctrl_t                ctrl;
  logic                 run_set, run_clr, done_evt, active;
  logic [NUM_FLAGS-1:0] wr_clr, evt, status_q;

  lcd_ctl_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)
  ) u_regs (
    .clk_i, .rst_ni,
    .valid_i   (bus_valid_i),
    .write_i   (bus_write_i),
    .addr_i    (bus_addr_i),
    .wdata_i   (bus_wdata_i),
    .status_i  (status_q),
    .ctrl_o    (ctrl),
    .run_set_o (run_set),
    .run_clr_o (run_clr),
    .wr_clr_o  (wr_clr),
    .rdata_o   (bus_rdata_o)
  );

  lcd_ctl_seq u_seq (
    .clk_i, .rst_ni,
    .run_set_i   (run_set),
    .run_clr_i   (run_clr),
    .frame_end_i (frame_end_i),
    .active_o    (active),
    .done_o      (done_evt)
  );

  always_comb begin
    evt            = '0;
    evt[FLG_DONE]  = done_evt;
    evt[FLG_VSYNC] = active & vsync_i;
    evt[FLG_SYNC]  = active & sync_lost_i;
    evt[FLG_ACB]   = active & acb_i;
    evt[FLG_LINE]  = active & line_i;
    evt[FLG_FUF]   = active & fifo_underflow_i;
    evt[FLG_PAL]   = active & palette_done_i;
  end

  lcd_ctl_flags u_flags (
    .clk_i, .rst_ni,
    .set_i     (evt),
    .wr_clr_i  (wr_clr),
    .run_set_i (run_set),
    .run_clr_i (run_clr),
    .mode_i    (ctrl.mode),
    .flags_o   (status_q)
  );

  lcd_ctl_irq u_irq (
    .flags_i (status_q),
    .ie_i    (ctrl.ie),
    .irq_o   (irq_o)
  );

  assign active_o    = active;
  assign tft_o       = ctrl.tft;
  assign load_mode_o = ctrl.mode;
endmodule

// File: rtl/lcd_ctl_status_chk.sv
module lcd_ctl_status_chk #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 2,
  parameter int CTRL_ADDR = 0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_valid_i,
  input logic              bus_write_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic              frame_end_i,
  input logic              sync_lost_i,
  input logic              fifo_underflow_i,
  input logic              active_o,
  input logic              irq_o,
  input logic [6:0]        status_i
);
  logic ctrl_wr, run_wr, stop_wr;
  assign ctrl_wr = bus_valid_i & bus_write_i & (bus_addr_i == ADDR_W'(CTRL_ADDR));
  assign run_wr  = ctrl_wr & bus_wdata_i[0];
  assign stop_wr = ctrl_wr & ~bus_wdata_i[0];

  assert_stop_at_frame_end_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_o) |-> $past(frame_end_i));

  assert_done_on_stop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_o) |-> status_i[0]);

  assert_done_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i[0] && !run_wr) |=> status_i[0]);

  assert_fatal_irq_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i[2] || status_i[5]) |-> irq_o);

  assert_no_event_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_i[1]) |-> $past(active_o));

  assert_fatal_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_wr && !sync_lost_i && !fifo_underflow_i) |=> (!status_i[2] && !status_i[5]));
endmodule

bind lcd_ctl_status lcd_ctl_status_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .bus_valid_i      (bus_valid_i),
  .bus_write_i      (bus_write_i),
  .bus_addr_i       (bus_addr_i),
  .bus_wdata_i      (bus_wdata_i),
  .frame_end_i      (frame_end_i),
  .sync_lost_i      (sync_lost_i),
  .fifo_underflow_i (fifo_underflow_i),
  .active_o         (active_o),
  .irq_o            (irq_o),
  .status_i         (status_q)
);

// File: tb/tb_lcd_ctl_status.sv
module tb_lcd_ctl_status;
  localparam int DW = 32;
  localparam int AW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid = 1'b0, wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          fe = 0, vs = 0, sl = 0, acb = 0, ln = 0, fuf = 0, pal = 0;
  logic          active, tft, irq;
  logic [1:0]    lmode;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  lcd_ctl_status dut (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_valid_i(valid), .bus_write_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata),
    .frame_end_i(fe), .vsync_i(vs), .sync_lost_i(sl), .acb_i(acb), .line_i(ln),
    .fifo_underflow_i(fuf), .palette_done_i(pal),
    .active_o(active), .tft_o(tft), .load_mode_o(lmode), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive for one rising edge, return on the following falling edge
  task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    valid = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk);
    valid = 0; wr = 0;
  endtask

  // strobe vector: 0 frame_end,1 vsync,2 sync,3 acb,4 line,5 fuf,6 pal
  task automatic pulse(input logic [6:0] s);
    {pal, fuf, ln, acb, sl, vs, fe} = s;
    @(negedge clk);
    {pal, fuf, ln, acb, sl, vs, fe} = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    @(negedge clk); @(negedge clk);
    // R1 reset state
    rd(0, d); chk("R1 ctrl", d, 0);
    rd(1, d); chk("R1 status", d, 0);
    chk("R1 active", active, 0);
    chk("R1 irq", irq, 0);
    rst_n = 1;
    @(negedge clk);

    // R3 strobes ignored while idle
    pulse(7'h7E);
    rd(1, d); chk("R3 idle strobes", d, 0);
    chk("R3 idle irq", irq, 0);

    // R2 field readback
    bus_wr(0, 32'hFFFF_FFFF);
    rd(0, d); chk("R2 readback", d, 32'h0030_00FD);
    chk("R2 tft", tft, 1);
    chk("R2 mode", lmode, 2'b11);
    chk("R3 active after run", active, 1);
    bus_wr(0, 32'h0020_0001);  // frame only, no enables, tft 0
    chk("R2 tft cleared", tft, 0);
    chk("R2 mode 10", lmode, 2'b10);

    // R6/R10 fatal flags
    pulse(7'h24);
    rd(1, d); chk("R6 fatal set", d, 32'h24);
    chk("R10 irq unmasked", irq, 1);
    bus_wr(1, 32'h0);
    rd(1, d); chk("R6 status write keeps fatal", d, 32'h24);

    // R8 palette in frame-only mode, R7 clearable flags
    pulse(7'h5A);  // vsync acb line pal
    rd(1, d); chk("R7 flags set", d, 32'h7E);
    bus_wr(1, 32'h0000_0008);  // keep acb
    rd(1, d); chk("R7/R8 partial clear", d, 32'h6C);

    // R4 deferred stop, R6/R8 clear on stop
    bus_wr(0, 32'h0020_0008);  // run=0, done enable
    rd(1, d); chk("R6/R8 cleared by stop", d, 32'h08);
    chk("R4 still active", active, 1);
    idle(3);
    chk("R4 still active later", active, 1);
    pulse(7'h01);
    chk("R4 stopped at frame end", active, 0);
    rd(1, d); chk("R4 done set", d, 32'h09);
    chk("R9 done irq", irq, 1);

    // R5 done sticky
    bus_wr(1, 32'h0);
    rd(1, d); chk("R5 done survives status write", d, 32'h01);
    bus_wr(0, 32'h0020_0000);  // stop while idle
    rd(1, d); chk("R5 done survives idle stop", d, 32'h01);
    bus_wr(0, 32'h0010_0001);  // run, palette-only
    rd(1, d); chk("R5 done cleared by run", d, 32'h0);

    // R4 cancel of pending stop
    bus_wr(0, 32'h0010_0000);
    bus_wr(0, 32'h0010_0001);
    pulse(7'h01);
    chk("R4 cancel keeps active", active, 1);
    rd(1, d); chk("R4 cancel no done", d, 0);

    // R8 palette-only mode: status write clears
    pulse(7'h40);
    bus_wr(1, 32'h0000_0040);
    rd(1, d); chk("R8 kept by 1", d, 32'h40);
    bus_wr(1, 32'h0);
    rd(1, d); chk("R8 cleared in palette-only", d, 32'h0);

    // R11 event wins over clear
    valid = 1; wr = 1; addr = 1; wdata = 0; vs = 1;
    @(negedge clk);
    valid = 0; wr = 0; vs = 0;
    rd(1, d); chk("R11 set beats clear", d, 32'h02);
    bus_wr(1, 32'h0);

    // R9 sweep: flag patterns x done x every enable mask
    for (int dn = 0; dn < 2; dn++) begin
      for (int p = 0; p < 16; p++) begin
        logic v_e, a_e, l_e, p_e;
        logic [31:0] exp_st;
        v_e = p[0]; a_e = p[1]; l_e = p[2]; p_e = p[3];
        bus_wr(0, 32'h0010_0001);
        bus_wr(1, 32'h0);
        pulse({p_e, 1'b0, l_e, a_e, 1'b0, v_e, 1'b0});
        if (dn == 1) begin
          bus_wr(0, 32'h0010_0000);
          pulse(7'h01);
        end
        exp_st = {25'd0, p_e, 1'b0, l_e, a_e, 1'b0, v_e, dn[0]};
        for (int m = 0; m < 32; m++) begin
          logic exp_irq;
          bus_wr(0, 32'h0010_0000 | (m << 2) | ((dn == 1) ? 0 : 1));
          exp_irq = (dn[0] & m[1]) | (v_e & m[0]) | (p_e & m[2]) | (l_e & m[4]);
          rd(1, d); chk("R9 sweep status", d, exp_st);
          chk("R9 sweep irq", irq, exp_irq);
        end
      end
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule